// File: doc/BRIEF.md
# Thread Suspend and Wakeup Controller

This controller lets each hardware thread stop issuing work until an event it cares about occurs. The thread does not poll and takes no interrupt. A thread asks to wait by pulsing its wait request. The controller then drops that thread's run-enable. It raises the run-enable again, with no context switch or handler, as soon as an enabled event source for that thread fires.

Three kinds of event source are supported. An inter-processor interrupt is addressed by thread index and leaves a sticky per-thread pending bit, which software clears with a write. A messaging interrupt arrives as a per-thread pulse. An invalidation wakes a thread when a broadcast line invalidation matches the address that thread registered to watch. Each thread has its own source-enable mask. Pulse events that reach a running thread through an enabled source are remembered, so a wait that follows them returns at once and no event is lost. The default build serves 68 threads: 17 cores with four threads each.

Top module: `thread_wake_ctrl`

## Requirements
- R1: After reset every run-enable is 1, every mask is 0, no inter-processor interrupt is pending, no watch address is registered, and no event is remembered.
- R2: A wait request from a running thread with no enabled event present and none remembered drives that thread's run-enable to 0 in the cycle after the request.
- R3: A sleeping thread whose enabled source fires has its run-enable at 1 in the cycle after the event, and stays running until its next wait.
- R4: An event from a source whose mask bit is 0 neither wakes the thread nor is remembered for a later wait.
- R5: A messaging or invalidation event on an enabled source while the thread runs is remembered. The next wait then completes at once (run-enable stays 1), and this consumes the memory, so the wait after it suspends.
- R6: An inter-processor interrupt to thread index T sets T's pending bit. While that bit is set and enabled, every wait of T completes at once. A clear write to T removes the bit. When a set and a clear reach the same thread in one cycle, the set wins.
- R7: The invalidation source fires for a thread only when that thread has a registered watch address that equals the invalidated address.
- R8: An event, a mask write, a watch write or a clear that is addressed to one thread has no effect on any other thread.
- R9: Mask bit positions: bit 0 enables inter-processor interrupts, bit 1 enables messaging interrupts, and bit 2 enables invalidation matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req | input | NUM_THREADS | Per-thread suspend request pulse |
| run_en | output | NUM_THREADS | Per-thread run-enable |
| cfg_we | input | 1 | Mask write strobe |
| cfg_thr | input | THR_W | Thread addressed by the mask write |
| cfg_mask | input | 3 | New source-enable mask (bit 0 IPI, bit 1 messaging, bit 2 invalidation) |
| ipi_valid | input | 1 | Inter-processor interrupt strobe |
| ipi_target | input | THR_W | Target thread index of the interrupt |
| ipi_clr_we | input | 1 | Pending-bit clear strobe |
| ipi_clr_thr | input | THR_W | Thread whose pending bit is cleared |
| msg_irq | input | NUM_THREADS | Per-thread messaging interrupt pulses |
| watch_we | input | 1 | Watch-address write strobe |
| watch_thr | input | THR_W | Thread registering the watch address |
| watch_addr | input | ADDR_W | Line address to watch |
| inv_valid | input | 1 | Line invalidation broadcast strobe |
| inv_addr | input | ADDR_W | Invalidated line address |

## Verification
Every result is due one clock edge after the stimulus that causes it. A wait request or a qualifying event sampled at an edge changes run-enable at that same edge, so the value is seen in the following cycle. Mask, watch and clear writes take effect for stimulus in the next cycle. The bench drives each stimulus on a falling edge and samples run-enable at the next falling edge, half a period after the register updates. For each "ignored" case it also checks that a later wait still suspends, which shows that nothing was remembered.

// File: rtl/twk_pkg.sv
package twk_pkg;
   localparam int SRC_N   = 3;
   localparam int SRC_IPI = 0;
   localparam int SRC_MSG = 1;
   localparam int SRC_INV = 2;
   typedef logic [SRC_N-1:0] src_vec_t;
   // sources whose events are pulses and must be remembered while running
   localparam src_vec_t PULSE_SRCS = src_vec_t'((1 << SRC_MSG) | (1 << SRC_INV));
endpackage

// File: rtl/twk_src.sv
module twk_src
   import twk_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter bit HAS_WATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ipi_hit,
   input  logic              ipi_clr,
   input  logic              msg_ev,
   input  logic              watch_set,
   input  logic [ADDR_W-1:0] watch_addr,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output src_vec_t          ev
);
   logic ipi_pend;
   logic inv_match;

   always_ff @(posedge clk) begin
      if (!rst_n)       ipi_pend <= 1'b0;
      else if (ipi_hit) ipi_pend <= 1'b1;   // set beats clear
      else if (ipi_clr) ipi_pend <= 1'b0;
   end

   generate
      if (HAS_WATCH) begin : g_watch
         logic              w_vld;
         logic [ADDR_W-1:0] w_addr;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               w_vld  <= 1'b0;
               w_addr <= '0;
            end else if (watch_set) begin
               w_vld  <= 1'b1;
               w_addr <= watch_addr;
            end
         end
         assign inv_match = inv_valid && w_vld && (w_addr == inv_addr);
      end else begin : g_nowatch
         logic unused_w;
         assign unused_w  = ^{watch_set, watch_addr, inv_valid, inv_addr};
         assign inv_match = 1'b0;
      end
   endgenerate

   always_comb begin
      ev          = '0;
      ev[SRC_IPI] = ipi_pend | ipi_hit;
      ev[SRC_MSG] = msg_ev;
      ev[SRC_INV] = inv_match;
   end

   AST_IPI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_hit |=> ev[SRC_IPI]);                                     // R6
   AST_IPI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_clr && !ipi_hit) |=> (!ev[SRC_IPI] || ipi_hit));         // R6
   AST_INV_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !inv_valid |-> !ev[SRC_INV]);                                 // R7
endmodule

// File: rtl/twk_thread.sv
module twk_thread
   import twk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wait_req,
   input  logic     cfg_we,
   input  src_vec_t cfg_mask,
   input  src_vec_t ev,
   output logic     run
);
   src_vec_t mask;
   logic     lat;
   logic     hit;
   logic     pulse_hit;

   assign pulse_hit = |(mask & ev & PULSE_SRCS);
   assign hit       = (|(mask & ev)) | lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '0;
         lat  <= 1'b0;
         run  <= 1'b1;
      end else begin
         if (cfg_we) mask <= cfg_mask;
         if (run) begin
            if (wait_req && !hit) run <= 1'b0;
         end else if (hit) begin
            run <= 1'b1;
         end
         if (hit && (wait_req || !run)) lat <= 1'b0;
         else if (run)                  lat <= lat | pulse_hit;
      end
   end

   AST_SLEEP_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wait_req && !hit) |=> !run);                          // R2
   AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && hit) |=> run);                                       // R3
   AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !hit) |=> !run);                                     // R4
   AST_WAIT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wait_req && hit) |=> (run && !lat));                  // R5
endmodule

// File: rtl/thread_wake_ctrl.sv
module thread_wake_ctrl
   import twk_pkg::*;
#(
   parameter int NUM_THREADS = 68,
   parameter int ADDR_W      = 16,
   parameter bit HAS_WATCH   = 1'b1,
   localparam int THR_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] wait_req,
   output logic [NUM_THREADS-1:0] run_en,
   input  logic                   cfg_we,
   input  logic [THR_W-1:0]       cfg_thr,
   input  logic [SRC_N-1:0]       cfg_mask,
   input  logic                   ipi_valid,
   input  logic [THR_W-1:0]       ipi_target,
   input  logic                   ipi_clr_we,
   input  logic [THR_W-1:0]       ipi_clr_thr,
   input  logic [NUM_THREADS-1:0] msg_irq,
   input  logic                   watch_we,
   input  logic [THR_W-1:0]       watch_thr,
   input  logic [ADDR_W-1:0]      watch_addr,
   input  logic                   inv_valid,
   input  logic [ADDR_W-1:0]      inv_addr
);
   generate
      if (NUM_THREADS < 2) begin : g_bad_threads
         $error("thread_wake_ctrl: NUM_THREADS must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("thread_wake_ctrl: ADDR_W must be at least 1");
      end
   endgenerate

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      src_vec_t ev;
      logic     sel_ipi, sel_clr, sel_cfg, sel_watch;

      assign sel_ipi   = ipi_valid  && (ipi_target  == THR_W'(t));
      assign sel_clr   = ipi_clr_we && (ipi_clr_thr == THR_W'(t));
      assign sel_cfg   = cfg_we     && (cfg_thr     == THR_W'(t));
      assign sel_watch = watch_we   && (watch_thr   == THR_W'(t));

      twk_src #(.ADDR_W(ADDR_W), .HAS_WATCH(HAS_WATCH)) u_src (
         .clk        (clk),
         .rst_n      (rst_n),
         .ipi_hit    (sel_ipi),
         .ipi_clr    (sel_clr),
         .msg_ev     (msg_irq[t]),
         .watch_set  (sel_watch),
         .watch_addr (watch_addr),
         .inv_valid  (inv_valid),
         .inv_addr   (inv_addr),
         .ev         (ev)
      );

      twk_thread u_thr (
         .clk      (clk),
         .rst_n    (rst_n),
         .wait_req (wait_req[t]),
         .cfg_we   (sel_cfg),
         .cfg_mask (cfg_mask),
         .ev       (ev),
         .run      (run_en[t])
      );

      AST_RUN_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_en[t] && !sel_ipi && !msg_irq[t] && !inv_valid) |=>
            (!run_en[t] || $past(ev[SRC_IPI])));                    // R8
   end

   AST_RESET_RUNNING: assert property (@(posedge clk)
      $past(!rst_n) |-> (&run_en));                                 // R1
endmodule

// File: tb/thread_wake_ctrl_bench.sv
module thread_wake_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NT  = 8;
   localparam int AW  = 8;
   localparam int TW  = 3;
   localparam int NV  = 11;
   // vector: {wait, msg, inv_valid, inv_addr[7:0], expected run of thread 2}
   localparam logic [11:0] VEC [NV] = '{
      {1'b1,1'b0,1'b0,8'h00,1'b0},  // R2 sleep
      {1'b0,1'b0,1'b0,8'h00,1'b0},  // stays asleep
      {1'b0,1'b0,1'b1,8'h5B,1'b0},  // R7 wrong address
      {1'b0,1'b0,1'b1,8'h5A,1'b1},  // R7/R3 match wakes
      {1'b0,1'b1,1'b0,8'h00,1'b1},  // R5 msg while running
      {1'b1,1'b0,1'b0,8'h00,1'b1},  // R5 wait completes at once
      {1'b1,1'b0,1'b0,8'h00,1'b0},  // R5 memory consumed
      {1'b0,1'b1,1'b0,8'h00,1'b1},  // R3 msg wakes
      {1'b1,1'b0,1'b0,8'h00,1'b0},  // R2
      {1'b0,1'b0,1'b0,8'h00,1'b0},
      {1'b0,1'b1,1'b0,8'h00,1'b1}   // R3
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NT-1:0] wait_req = '0, msg_irq = '0, run_en;
   logic cfg_we = 0, ipi_valid = 0, ipi_clr_we = 0, watch_we = 0, inv_valid = 0;
   logic [TW-1:0] cfg_thr = '0, ipi_target = '0, ipi_clr_thr = '0, watch_thr = '0;
   logic [2:0] cfg_mask = '0;
   logic [AW-1:0] watch_addr = '0, inv_addr = '0;
   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thread_wake_ctrl #(.NUM_THREADS(NT), .ADDR_W(AW)) u_thread_wake_ctrl (
      .clk, .rst_n, .wait_req, .run_en, .cfg_we, .cfg_thr, .cfg_mask,
      .ipi_valid, .ipi_target, .ipi_clr_we, .ipi_clr_thr, .msg_irq,
      .watch_we, .watch_thr, .watch_addr, .inv_valid, .inv_addr);

   task automatic quiet();
      wait_req = '0; msg_irq = '0; cfg_we = 0; ipi_valid = 0;
      ipi_clr_we = 0; watch_we = 0; inv_valid = 0;
   endtask

   task automatic step();   // inputs set after a falling edge; sample at the next one
      @(negedge clk);
      quiet();
   endtask

   task automatic chk(string req, int thr, logic exp);
      checks++;
      if (run_en[thr] !== exp) begin
         errors++;
         $display("FAIL %s thread %0d run_en actual %b expected %b", req, thr, run_en[thr], exp);
      end
   endtask

   task automatic set_mask(int thr, logic [2:0] m);
      cfg_we = 1; cfg_thr = TW'(thr); cfg_mask = m; step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (run_en !== '1) begin
         errors++;
         $display("FAIL R1 run_en actual %h expected %h", run_en, {NT{1'b1}});
      end
      // R1: masks are zero after reset, so a message with the wait does not hold the thread
      wait_req[6] = 1; msg_irq[6] = 1; step();
      chk("R1", 6, 1'b0);

      // table walk on thread 2: bit 1 messaging, bit 2 invalidation (R9)
      set_mask(2, 3'b110);
      watch_we = 1; watch_thr = 3'd2; watch_addr = 8'h5A; step();
      for (int i = 0; i < NV; i++) begin
         wait_req[2] = VEC[i][11];
         msg_irq[2]  = VEC[i][10];
         inv_valid   = VEC[i][9];
         inv_addr    = VEC[i][8:1];
         step();
         chk($sformatf("R3/R5/R7 vec %0d", i), 2, VEC[i][0]);
      end

      // R4: a disabled source is not remembered
      msg_irq[4] = 1; step();
      set_mask(4, 3'b010);
      wait_req[4] = 1; step();
      chk("R4 disabled not remembered", 4, 1'b0);

      // R9/R4: thread 1 enables only bit 0 (IPI); a message is ignored
      set_mask(1, 3'b001);
      wait_req[1] = 1; step();
      chk("R2", 1, 1'b0);
      msg_irq[1] = 1; inv_valid = 1; inv_addr = 8'h5A; step();
      chk("R4 masked msg", 1, 1'b0);
      // R8: an IPI to thread 5 leaves thread 1 asleep
      ipi_valid = 1; ipi_target = 3'd5; step();
      chk("R8 other target", 1, 1'b0);
      // R6: an IPI to thread 1 wakes it one cycle later
      ipi_valid = 1; ipi_target = 3'd1; step();
      chk("R6 wake", 1, 1'b1);
      wait_req[1] = 1; step();
      chk("R6 pending completes wait", 1, 1'b1);
      ipi_clr_we = 1; ipi_clr_thr = 3'd1; step();
      wait_req[1] = 1; step();
      chk("R6 cleared", 1, 1'b0);
      // R6: the set wins over a clear in the same cycle
      ipi_valid = 1; ipi_target = 3'd1; ipi_clr_we = 1; ipi_clr_thr = 3'd1; step();
      chk("R6 set wins wake", 1, 1'b1);
      wait_req[1] = 1; step();
      chk("R6 set wins still pending", 1, 1'b1);
      // R8: a clear for thread 5 leaves thread 1 pending
      ipi_clr_we = 1; ipi_clr_thr = 3'd5; step();
      wait_req[1] = 1; step();
      chk("R8 clear other thread", 1, 1'b1);
      ipi_clr_we = 1; ipi_clr_thr = 3'd1; step();
      wait_req[1] = 1; step();
      chk("R6 cleared again", 1, 1'b0);
      // R8: the IPI pending on thread 5 is not enabled there and thread 3 is untouched
      wait_req[5] = 1; step();
      chk("R8 thread 5 masked IPI", 5, 1'b0);
      chk("R8 thread 3 running", 3, 1'b1);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule